// File: doc/BRIEF.md
# Program/Erase Busy Status Reporter

This block produces the word a host reads while a nonvolatile memory is busy with an internal word program or erase, so that software can tell when the write has finished. A one-cycle launch pulse stands for the rising edge of the final write strobe of a command sequence: the fourth strobe for a program, the sixth for a sector or chip erase. The launch starts an internal countdown whose length depends on the operation. While that countdown runs, every read returns a status word instead of array contents.

In the status word, bit 7 is a polling bit. For a program it reads as the inverse of bit 7 of the word being written. For an erase it reads 0. Bit 6 alternates on every separate read access. The remaining bits come from a fixed filler pattern. When the countdown ends, bit 7 shows its final value at once: the true bit for a program, or 1 for an erase, since an erased word is all ones. The other bits need a short settling window after that. Once the window closes, reads return the normal array data.

The three durations scale down the real maximums (20 µs program, 25 ms sector erase, 100 ms chip erase) and are set as cycle-count parameters.

Top module: `wstat_reporter`

## Requirements
- R1: A `start` pulse seen at a rising clock edge while not busy, with `opc` equal to 0 (program), 1 (sector erase) or 2 (chip erase), raises `busy` after that edge. `busy` then stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles respectively.
- R2: During a program, a read returns bit 7 equal to the inverse of the `prog_bit7` value captured at launch.
- R3: During a sector or chip erase, a read returns bit 7 equal to 0.
- R4: While busy, bit 6 flips once for each read access, meaning a falling `out_en_n` while `chip_en_n` is low. Holding `out_en_n` low for several cycles does not flip it again.
- R5: While busy or settling, bits 15:8 and 5:0 of a read equal the same bits of parameter FILL (default 16'h5A25).
- R6: For SETTLE_CYC cycles after `busy` falls, a read returns the final bit 7 (the captured program bit, or 1 for an erase). In this window bit 6 holds its last value and the other bits follow FILL.
- R7: When neither busy nor settling, a read returns `array_data` unchanged.
- R8: `rd_data` is 0 whenever `chip_en_n` or `out_en_n` is high. A falling `out_en_n` while `chip_en_n` is high does not advance bit 6.
- R9: A `start` pulse while busy is ignored. The operation kind, the polling bit and the remaining busy time are all kept.
- R10: A `start` pulse with `opc` equal to 3 launches nothing.
- R11: After reset, `busy` is 0 and the toggle bit is 0, so the first busy read returns bit 6 equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse marking the final write strobe of a command |
| opc | input | 2 | Operation: 0 program, 1 sector erase, 2 chip erase, 3 none |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed, captured at launch |
| array_data | input | 16 | Normal array read word |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable; its falling edge marks a read access |
| busy | output | 1 | Internal operation in progress |
| rd_data | output | 16 | Read data returned to the host |

## Verification
`busy` rises on the clock edge that samples `start`. It is counted on every following rising edge, so the count equals the parameter duration. `rd_data` is combinational from registered state. A read access is seen on the first rising edge after `out_en_n` falls, and bit 6 shows its new value from then on. For that reason the bench drives inputs on falling edges and samples `rd_data` one full cycle after lowering `out_en_n`. The settling-window read is sampled one cycle after the first falling edge that shows `busy` low. The idle read is sampled only after SETTLE_CYC plus two further cycles.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        OPC_PROG = 2'd0,
        OPC_SECT = 2'd1,
        OPC_CHIP = 2'd2,
        OPC_NONE = 2'd3
    } opc_t;

endpackage

// File: rtl/wstat_seq.sv
module wstat_seq
    import wstat_pkg::*;
#(
    parameter int PROG_CYC   = 24,
    parameter int SECT_CYC   = 60,
    parameter int CHIP_CYC   = 150,
    parameter int SETTLE_CYC = 5,
    localparam int MAXC = (CHIP_CYC > SECT_CYC) ?
                          ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                          ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC),
    localparam int MAXA = (MAXC > SETTLE_CYC) ? MAXC : SETTLE_CYC,
    localparam int CW   = $clog2(MAXA + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    opc,
    input  logic          prog_bit7,
    output phase_t        phase_o,
    output logic          erase_o,
    output logic          pbit_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] PROG_L = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] SECT_L = CW'(SECT_CYC - 1);
    localparam logic [CW-1:0] CHIP_L = CW'(CHIP_CYC - 1);
    localparam logic [CW-1:0] SETL_L = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        phase_t        ph;
        logic          erase;
        logic          pbit;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic launch;

    always_comb begin
        st_d   = st_q;
        launch = start && (st_q.ph != PH_BUSY) && (opc_t'(opc) != OPC_NONE);
        case (st_q.ph)
            PH_BUSY: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_SETTLE;
                    st_d.cnt = SETL_L;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_SETTLE: begin
                if (st_q.cnt == '0) st_d.ph  = PH_IDLE;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            default: st_d.cnt = '0;
        endcase
        if (launch) begin
            st_d.ph    = PH_BUSY;
            st_d.erase = (opc_t'(opc) != OPC_PROG);
            st_d.pbit  = prog_bit7;
            case (opc_t'(opc))
                OPC_PROG: st_d.cnt = PROG_L;
                OPC_SECT: st_d.cnt = SECT_L;
                default:  st_d.cnt = CHIP_L;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, erase: 1'b0, pbit: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign erase_o = st_q.erase;
    assign pbit_o  = st_q.pbit;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/wstat_access.sv
module wstat_access (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en_n,
    input  logic out_en_n,
    input  logic count_en,
    output logic tog_o
);

    typedef struct packed {
        logic oe_n_prev;
        logic tog;
    } acc_t;

    acc_t st_d, st_q;
    logic access_fall;

    always_comb begin
        st_d           = st_q;
        access_fall    = st_q.oe_n_prev && !out_en_n && !chip_en_n;
        st_d.oe_n_prev = out_en_n;
        if (access_fall && count_en) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{oe_n_prev: 1'b1, tog: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tog_o = st_q.tog;

endmodule

// File: rtl/wstat_mux.sv
module wstat_mux
    import wstat_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] FILL     = 16'h5A25,
    parameter int           POLL_BIT = 7,
    parameter int           TOG_BIT  = 6
) (
    input  phase_t       phase,
    input  logic         erase,
    input  logic         pbit,
    input  logic         tog,
    input  logic         rd_en,
    input  logic [W-1:0] array_data,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] status_w;

    always_comb begin
        status_w          = FILL;
        status_w[TOG_BIT] = tog;
        if (phase == PH_BUSY) status_w[POLL_BIT] = erase ? 1'b0 : ~pbit;
        else                  status_w[POLL_BIT] = erase ? 1'b1 : pbit;

        if (!rd_en)                 rd_data = '0;
        else if (phase == PH_IDLE)  rd_data = array_data;
        else                        rd_data = status_w;
    end

endmodule

// File: rtl/wstat_reporter.sv
module wstat_reporter
    import wstat_pkg::*;
#(
    parameter int            W          = 16,
    parameter int            PROG_CYC   = 24,
    parameter int            SECT_CYC   = 60,
    parameter int            CHIP_CYC   = 150,
    parameter int            SETTLE_CYC = 5,
    parameter logic [W-1:0]  FILL       = 16'h5A25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   opc,
    input  logic         prog_bit7,
    input  logic [W-1:0] array_data,
    input  logic         chip_en_n,
    input  logic         out_en_n,
    output logic         busy,
    output logic [W-1:0] rd_data
);

    localparam int MAXC = (CHIP_CYC > SECT_CYC) ?
                          ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                          ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC);
    localparam int MAXA = (MAXC > SETTLE_CYC) ? MAXC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXA + 1);

    phase_t        phase;
    logic          erase_q;
    logic          pbit_q;
    logic [CW-1:0] cnt_q;
    logic          tog_q;

    wstat_seq #(
        .PROG_CYC  (PROG_CYC),
        .SECT_CYC  (SECT_CYC),
        .CHIP_CYC  (CHIP_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opc      (opc),
        .prog_bit7(prog_bit7),
        .phase_o  (phase),
        .erase_o  (erase_q),
        .pbit_o   (pbit_q),
        .cnt_o    (cnt_q)
    );

    wstat_access u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_en_n(chip_en_n),
        .out_en_n (out_en_n),
        .count_en (phase == PH_BUSY),
        .tog_o    (tog_q)
    );

    wstat_mux #(
        .W   (W),
        .FILL(FILL)
    ) u_mux (
        .phase     (phase),
        .erase     (erase_q),
        .pbit      (pbit_q),
        .tog       (tog_q),
        .rd_en     (!chip_en_n && !out_en_n),
        .array_data(array_data),
        .rd_data   (rd_data)
    );

    assign busy = (phase == PH_BUSY);

endmodule

// File: rtl/wstat_reporter_chk.sv
module wstat_reporter_chk
    import wstat_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          chip_en_n,
    input logic          out_en_n,
    input logic          busy,
    input logic [W-1:0]  rd_data,
    input phase_t        phase,
    input logic          erase_q,
    input logic          pbit_q,
    input logic [CW-1:0] cnt_q,
    input logic          tog_q
);

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R1

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !erase_q && !chip_en_n && !out_en_n) |-> (rd_data[7] == !pbit_q)); // R2

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && erase_q && !chip_en_n && !out_en_n) |-> (rd_data[7] == 1'b0)); // R3

    AST_TOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog_q)); // R4

    AST_SETTLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (phase == PH_SETTLE)); // R6

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n || out_en_n) |-> (rd_data == '0)); // R8

    AST_KEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt_q != '0) |=> busy); // R9

    AST_KEEP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(erase_q) && $stable(pbit_q))); // R9

endmodule

bind wstat_reporter wstat_reporter_chk #(.W(W), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .chip_en_n(chip_en_n),
    .out_en_n (out_en_n),
    .busy     (busy),
    .rd_data  (rd_data),
    .phase    (phase),
    .erase_q  (erase_q),
    .pbit_q   (pbit_q),
    .cnt_q    (cnt_q),
    .tog_q    (tog_q)
);

// File: tb/wstat_reporter_test.sv
module wstat_reporter_test;

    localparam int          PROG = 24;
    localparam int          SECT = 60;
    localparam int          CHIP = 150;
    localparam int          SETL = 5;
    localparam logic [15:0] FILL = 16'h5A25;
    localparam logic [15:0] FMASK = 16'hFF3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  opc = 2'd0;
    logic        prog_bit7 = 1'b0;
    logic [15:0] array_data = 16'h0000;
    logic        chip_en_n = 1'b0;
    logic        out_en_n = 1'b1;
    logic        busy;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    logic tog_m = 1'b0;
    logic clr_b = 1'b0;
    int bcnt = 0;

    // opc[18:17], prog_bit7[16], array word[15:0]
    localparam logic [18:0] VEC [6] = '{
        {2'd0, 1'b1, 16'h1234},
        {2'd0, 1'b0, 16'hBEEF},
        {2'd1, 1'b0, 16'hFFFF},
        {2'd2, 1'b1, 16'hFFFF},
        {2'd1, 1'b1, 16'h00C3},
        {2'd0, 1'b1, 16'h8001}
    };

    always #2.5 clk = ~clk;

    wstat_reporter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opc(opc),
        .prog_bit7(prog_bit7), .array_data(array_data),
        .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .busy(busy), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (clr_b)     bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
    end

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int dur_of(input logic [1:0] op);
        return (op == 2'd0) ? PROG : (op == 2'd1) ? SECT : CHIP;
    endfunction

    task automatic launch(input logic [1:0] op, input logic b7);
        @(negedge clk);
        start = 1'b1; opc = op; prog_bit7 = b7; clr_b = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_b = 1'b0;
    endtask

    // one read access; returns word sampled one cycle after out_en_n falls
    task automatic do_read(output logic [15:0] w, input bit counts);
        out_en_n = 1'b0;
        @(negedge clk);
        if (counts && !chip_en_n) tog_m = ~tog_m;
        w = rd_data;
        out_en_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle_busy();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    endtask

    task automatic run_case(input logic [1:0] op, input logic b7, input logic [15:0] ad);
        logic [15:0] w;
        logic        p7, f7;
        array_data = ad;
        launch(op, b7);
        check({15'd0, busy}, 16'd1, "R1 busy after launch");
        p7 = (op == 2'd0) ? ~b7 : 1'b0;
        f7 = (op == 2'd0) ? b7 : 1'b1;
        for (int r = 0; r < 3; r++) begin
            do_read(w, 1'b1);
            if (op == 2'd0) check({15'd0, w[7]}, {15'd0, p7}, "R2 program poll bit");
            else            check({15'd0, w[7]}, {15'd0, p7}, "R3 erase poll bit");
            check({15'd0, w[6]}, {15'd0, tog_m}, "R4 toggle bit");
            check(w & FMASK, FILL & FMASK, "R5 filler bits busy");
        end
        wait_idle_busy();
        check(16'(bcnt), 16'(dur_of(op)), "R1 busy duration");
        do_read(w, 1'b0);
        check({15'd0, w[7]}, {15'd0, f7}, "R6 final poll bit");
        check({15'd0, w[6]}, {15'd0, tog_m}, "R6 toggle frozen");
        check(w & FMASK, FILL & FMASK, "R6 filler bits settle");
        repeat (SETL + 2) @(negedge clk);
        do_read(w, 1'b0);
        check(w, ad, "R7 idle array data");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] w, w2;
        // reset state
        repeat (3) @(negedge clk);
        check({15'd0, busy}, 16'd0, "R11 busy in reset");
        check(rd_data, 16'h0000, "R8 bus quiet in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({15'd0, busy}, 16'd0, "R11 busy after reset");
        array_data = 16'hA5A5;
        do_read(w, 1'b0);
        check(w, 16'hA5A5, "R7 idle read after reset");

        // first busy read after reset sees toggle 1
        launch(2'd0, 1'b0);
        do_read(w, 1'b1);
        check({15'd0, w[6]}, 16'd1, "R11 first toggle value");
        check({15'd0, w[7]}, 16'd1, "R2 inverted zero");
        wait_idle_busy();
        repeat (SETL + 2) @(negedge clk);

        // vector table walk
        for (int i = 0; i < 6; i++) begin
            run_case(VEC[i][18:17], VEC[i][16], VEC[i][15:0]);
        end

        // R8: access with chip enable high does not advance the toggle
        launch(2'd1, 1'b0);
        chip_en_n = 1'b1;
        out_en_n = 1'b0;
        @(negedge clk);
        check(rd_data, 16'h0000, "R8 bus quiet with chip disabled");
        out_en_n = 1'b1;
        @(negedge clk);
        chip_en_n = 1'b0;
        do_read(w, 1'b1);
        check({15'd0, w[6]}, {15'd0, tog_m}, "R8 no toggle from deselected access");

        // R4: held output enable gives one flip only
        out_en_n = 1'b0;
        @(negedge clk);
        tog_m = ~tog_m;
        w = rd_data;
        repeat (3) @(negedge clk);
        w2 = rd_data;
        out_en_n = 1'b1;
        check({15'd0, w[6]}, {15'd0, tog_m}, "R4 held read flips once");
        check({15'd0, w2[6]}, {15'd0, tog_m}, "R4 held read stays");
        wait_idle_busy();
        check(16'(bcnt), 16'(SECT), "R1 sector duration");
        repeat (SETL + 2) @(negedge clk);

        // R9: start during busy is ignored
        launch(2'd0, 1'b1);
        repeat (4) @(negedge clk);
        start = 1'b1; opc = 2'd2; prog_bit7 = 1'b0;
        @(negedge clk);
        start = 1'b0;
        do_read(w, 1'b1);
        check({15'd0, w[7]}, 16'd0, "R9 poll bit kept");
        wait_idle_busy();
        check(16'(bcnt), 16'(PROG), "R9 duration kept");
        repeat (SETL + 2) @(negedge clk);

        // R10: opcode 3 launches nothing
        @(negedge clk);
        start = 1'b1; opc = 2'd3;
        @(negedge clk);
        start = 1'b0;
        check({15'd0, busy}, 16'd0, "R10 no launch");
        array_data = 16'h3C3C;
        do_read(w, 1'b0);
        check(w, 16'h3C3C, "R10 array still readable");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule